// File: doc/BRIEF.md
# Shared Channel Service Request Register

This block is a service request register shared by a host processor and a set of channel engines. Each channel owns a 2-bit field in one packed word. The host sets a field to a nonzero request code to ask its channel for service. The engine that serves the channel sets the field back to 00 when it finishes.

Field value 00 is reserved for the engine side, so a host write of 00 to any field leaves that field as it is. The host can therefore post a request to one channel by writing a word that is zero everywhere except in that channel's field. No read-modify-write is needed, and an engine clear that lands on another field during the host access is not lost.

A second register holds a 2-bit priority per channel, where 00 disables the channel. A request is shown on the pending output only when its channel's priority is nonzero. The intended setup order for a channel is:

1. Set its priority to 00.
2. Configure the channel.
3. Post the request.
4. Raise the priority.

Top module: `svc_req_reg`

## Requirements
- R1: After reset, every request field and every priority field reads 00 and no channel is pending.
- R2: A host write whose field for channel i is nonzero stores that value in the field at the next clock edge.
- R3: A host write whose field for channel i is 00 leaves the stored field unchanged, provided the engine of channel i does not clear it in the same cycle.
- R4: When eng_done[i] is high and the host does not write a nonzero value to field i, field i becomes 00 at the next clock edge.
- R5: When a nonzero host value and eng_done[i] reach field i in the same cycle, the host value is stored.
- R6: A clear from the engine of channel i never changes the field of any other channel.
- R7: A priority write stores every 2-bit field as written, 00 included. The codes are 00 disabled, 01 low, 10 medium and 11 high.
- R8: pending[i] is high exactly when request field i is nonzero and priority field i is nonzero.
- R9: Channel i occupies bits [2i+1:2i] in the request word, the priority word and both read words, so channel 7 is the most significant field and channel 0 the least significant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_en | input | 1 | Host writes the request word this cycle |
| host_wr_data | input | 2*NUM_CH | Request word from host; 00 fields are ignored |
| prio_wr_en | input | 1 | Host writes the priority word this cycle |
| prio_wr_data | input | 2*NUM_CH | Priority word from host |
| eng_done | input | NUM_CH | Per-channel service-complete clear |
| rd_data | output | 2*NUM_CH | Current request fields |
| prio_rd | output | 2*NUM_CH | Current priority fields |
| pending | output | NUM_CH | Per-channel request presented to the engines |

## Verification
An exhaustive sweep runs over every channel. For each one it covers every starting field value, every host field code and both states of the engine clear. This separates a stored write, an ignored 00 write, a plain clear and the host-wins collision.

During the sweep the other fields hold a fixed nonzero pattern. Any spill from the selected field into its neighbours therefore shows up in the read word.

A long pseudo-random phase mixes several host writes, multi-channel clears and priority changes in the same cycle. Each cycle it compares both read words and the pending vector against an arithmetic model. Directed writes to the top and bottom fields confirm the field positions.

// File: rtl/svc_req_reg.sv
module svc_req_reg #(
  parameter int NUM_CH = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_wr_en,
  input  logic [2*NUM_CH-1:0] host_wr_data,
  input  logic                prio_wr_en,
  input  logic [2*NUM_CH-1:0] prio_wr_data,
  input  logic [NUM_CH-1:0]   eng_done,
  output logic [2*NUM_CH-1:0] rd_data,
  output logic [2*NUM_CH-1:0] prio_rd,
  output logic [NUM_CH-1:0]   pending
);
  localparam int FW = 2;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [FW-1:0] fld_q;
    logic [FW-1:0] prio_q;
    logic [FW-1:0] host_fld;
    logic          host_hit;

    assign host_fld = host_wr_data[ch*FW +: FW];
    assign host_hit = host_wr_en && (host_fld != '0);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              fld_q <= '0;
      else if (host_hit)       fld_q <= host_fld;
      else if (eng_done[ch])   fld_q <= '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          prio_q <= '0;
      else if (prio_wr_en) prio_q <= prio_wr_data[ch*FW +: FW];
    end

    assign rd_data[ch*FW +: FW] = fld_q;
    assign prio_rd[ch*FW +: FW] = prio_q;
    assign pending[ch]          = (|fld_q) && (|prio_q);
  end
endmodule

module svc_req_reg_chk #(
  parameter int NUM_CH = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                host_wr_en,
  input logic [2*NUM_CH-1:0] host_wr_data,
  input logic                prio_wr_en,
  input logic [2*NUM_CH-1:0] prio_wr_data,
  input logic [NUM_CH-1:0]   eng_done,
  input logic [2*NUM_CH-1:0] rd_data,
  input logic [2*NUM_CH-1:0] prio_rd,
  input logic [NUM_CH-1:0]   pending
);
  p_prio_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
    prio_wr_en |=> prio_rd == $past(prio_wr_data));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    // R2
    p_host_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr_en && host_wr_data[2*i +: 2] != 2'b00)
      |=> rd_data[2*i +: 2] == $past(host_wr_data[2*i +: 2]));

    // R3
    p_zero_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!eng_done[i] && (!host_wr_en || host_wr_data[2*i +: 2] == 2'b00))
      |=> $stable(rd_data[2*i +: 2]));

    // R4
    p_engine_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_done[i] && (!host_wr_en || host_wr_data[2*i +: 2] == 2'b00))
      |=> rd_data[2*i +: 2] == 2'b00);

    // R5
    p_host_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_done[i] && host_wr_en && host_wr_data[2*i +: 2] != 2'b00)
      |=> rd_data[2*i +: 2] != 2'b00);

    // R8
    p_disabled_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (prio_rd[2*i +: 2] == 2'b00 || rd_data[2*i +: 2] == 2'b00) |-> !pending[i]);
  end
endmodule

bind svc_req_reg svc_req_reg_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en), .host_wr_data(host_wr_data),
  .prio_wr_en(prio_wr_en), .prio_wr_data(prio_wr_data), .eng_done(eng_done),
  .rd_data(rd_data), .prio_rd(prio_rd), .pending(pending));

// File: tb/tb_svc_req_reg.sv
`timescale 1ns/1ps
module tb_svc_req_reg;
  localparam int NCH = 8;
  localparam int W   = 2*NCH;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           host_wr_en = 1'b0;
  logic [W-1:0]   host_wr_data = '0;
  logic           prio_wr_en = 1'b0;
  logic [W-1:0]   prio_wr_data = '0;
  logic [NCH-1:0] eng_done = '0;
  logic [W-1:0]   rd_data, prio_rd;
  logic [NCH-1:0] pending;

  int checks = 0;
  int failures = 0;
  logic [W-1:0] m_req = '0;
  logic [W-1:0] m_pri = '0;

  always #2 clk = ~clk;

  svc_req_reg #(.NUM_CH(NCH)) dut (
    .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en), .host_wr_data(host_wr_data),
    .prio_wr_en(prio_wr_en), .prio_wr_data(prio_wr_data), .eng_done(eng_done),
    .rd_data(rd_data), .prio_rd(prio_rd), .pending(pending));

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [NCH-1:0] exp_pend(input logic [W-1:0] r, input logic [W-1:0] p);
    logic [NCH-1:0] v;
    for (int i = 0; i < NCH; i++) v[i] = (r[2*i +: 2] != 2'b00) && (p[2*i +: 2] != 2'b00);
    return v;
  endfunction

  // Drives one cycle at the falling edge, advances the model, samples at the next falling edge.
  task automatic step(input logic hw, input logic [W-1:0] hd, input logic pw,
                      input logic [W-1:0] pd, input logic [NCH-1:0] dn);
    host_wr_en = hw; host_wr_data = hd; prio_wr_en = pw; prio_wr_data = pd; eng_done = dn;
    for (int i = 0; i < NCH; i++) begin
      if (hw && hd[2*i +: 2] != 2'b00) m_req[2*i +: 2] = hd[2*i +: 2];
      else if (dn[i])                  m_req[2*i +: 2] = 2'b00;
    end
    if (pw) m_pri = pd;
    @(negedge clk);
    host_wr_en = 1'b0; eng_done = '0; prio_wr_en = 1'b0;
  endtask

  initial begin
    #800000;
    failures++;
    $display("FAIL watchdog all actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] lfsr = 32'h1ACE_B00C;
    repeat (3) @(negedge clk);
    chk("R1 req", rd_data, '0);
    chk("R1 prio", prio_rd, '0);
    chk("R1 pend", {8'h0, pending}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 field positions
    step(1'b1, 16'hC000, 1'b1, 16'h4000, '0);
    chk("R9 ch7 msb", rd_data, 16'hC000);
    chk("R9 ch7 pend", {8'h0, pending}, 16'h0080);
    step(1'b1, 16'h0002, 1'b0, '0, 8'h80);
    chk("R9 ch0 lsb", rd_data, 16'h0002);
    chk("R6 ch7 clear only", rd_data, m_req);

    // R7 priority including 00 fields
    step(1'b0, '0, 1'b1, 16'h1B00, '0);
    chk("R7 prio", prio_rd, 16'h1B00);
    step(1'b0, '0, 1'b1, 16'h0000, '0);
    chk("R7 prio zero", prio_rd, 16'h0000);
    chk("R8 disabled", {8'h0, pending}, '0);

    // Exhaustive sweep: channel x start value x host code x engine clear
    for (int ch = 0; ch < NCH; ch++)
      for (int v = 0; v < 4; v++)
        for (int h = 0; h < 4; h++)
          for (int d = 0; d < 2; d++) begin
            logic [W-1:0] bg;
            logic [W-1:0] hw;
            string tag;
            bg = 16'hBE6D;
            bg[2*ch +: 2] = 2'b01;
            step(1'b1, bg, 1'b1, 16'hFFFF, '0);
            if (v == 0) step(1'b0, '0, 1'b0, '0, NCH'(1) << ch);
            else begin
              hw = '0; hw[2*ch +: 2] = 2'(v);
              step(1'b1, hw, 1'b0, '0, '0);
            end
            hw = '0; hw[2*ch +: 2] = 2'(h);
            step(1'b1, hw, 1'b0, '0, d ? (NCH'(1) << ch) : '0);
            if (h != 0 && d != 0) tag = "R5 host wins";
            else if (h != 0)      tag = "R2 host store";
            else if (d != 0)      tag = "R4 engine clear";
            else                  tag = "R3 zero ignored";
            chk(tag, rd_data, m_req);
            chk("R8 pend sweep", {8'h0, pending}, {8'h0, exp_pend(m_req, m_pri)});
          end

    // Pseudo-random mix
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r1, r2;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]}; r1 = lfsr * 32'h9E37_79B1;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]}; r2 = lfsr * 32'h85EB_CA6B;
      step(r1[31], r1[15:0], r1[30] & r1[29], r2[15:0], r2[23:16] & r2[31:24]);
      chk("R6 random req", rd_data, m_req);
      chk("R7 random prio", prio_rd, m_pri);
      chk("R8 random pend", {8'h0, pending}, {8'h0, exp_pend(m_req, m_pri)});
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule